// File: doc/BRIEF.md
# Ethernet Media Port Auto-Selector

This block decides which of two physical media ports a 10 Mb/s Ethernet controller uses: the twisted-pair port or the attachment-unit (AUI) port. Software can fix the port by hand. It can also hand the choice to the block, which then follows the twisted-pair link state. A port change never cuts into a frame that is being sent. A change that is requested during a transmission waits until the transmitter goes idle.

The block also decides two more things. The first is whether link beat pulses go out on the twisted-pair port. The second is which low-power state a sleep request enters: snooze, which keeps the link alive, or coma, which is a deeper stop. Two configuration bits hold these settings, auto-select and awake. A hard reset clears them. A soft reset leaves them as they are. Link integrity detection and the pulse generator sit outside the block.

Top module: `media_port_selector`

## Requirements
- R1: With auto-select set and the link passing, the selected port becomes twisted-pair (`port_sel`=1) on the first clock edge at which `tx_active` is low.
- R2: With auto-select set and the link failing, the selected port becomes AUI (`port_sel`=0) on the first clock edge at which `tx_active` is low.
- R3: The link counts as passing when `rx_link_ok` is high, when `force_link` is high, or when both are high. It fails only when both are low.
- R4: `port_sel` is a register. It keeps its value on every edge at which `tx_active` is high, unless a soft reset occurs. A pending change takes effect at the first edge with `tx_active` low.
- R5: While auto-select is set, `link_pulse_en` is 1 whatever the link state and whatever port is selected.
- R6: With auto-select clear, the selected port follows `manual_port` (1 = twisted-pair, 0 = AUI), and `link_pulse_en` equals `port_sel`.
- R7: With `sleep_req` high, `snooze` is 1 and `coma` is 0 when awake is set and the twisted-pair port is selected. In every other case `coma` is 1 and `snooze` is 0. With `sleep_req` low, both are 0.
- R8: A hard reset (`rst_n` low at an edge) clears auto-select, awake and the port (AUI). A soft reset (`soft_rst` high) sets the port to AUI and leaves auto-select and awake unchanged.
- R9: Auto-select and awake load from `cfg_auto_sel` and `cfg_awake` only at an edge with `cfg_we` high. Otherwise they keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset; keeps the configuration bits |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_auto_sel | input | 1 | Auto-select value to write |
| cfg_awake | input | 1 | Awake value to write |
| manual_port | input | 1 | Software port choice, 1 = twisted-pair |
| rx_link_ok | input | 1 | Valid frames or link test pulses are being received |
| force_link | input | 1 | Forces the link to count as passing |
| tx_active | input | 1 | A transmission is in progress |
| sleep_req | input | 1 | Sleep request |
| port_sel | output | 1 | Selected port, 1 = twisted-pair, 0 = AUI |
| link_pulse_en | output | 1 | Enables link beat pulses on the twisted-pair port |
| snooze | output | 1 | Sleep entered in snooze mode |
| coma | output | 1 | Sleep entered in coma mode |

## Verification
The bench drives every combination of the eight control inputs, in two different orders, so that each one arrives from many different prior states. The sweep therefore covers a link that drops or comes back while a transmission is in progress. A design that switched ports in the middle of a frame, or that dropped the deferred change after the frame, would show the wrong `port_sel` on the first idle cycle. Directed cases cover the forced link test with no received traffic, awake set while the AUI port is selected (a wrong design would snooze instead of entering coma), and a soft reset that a wrong design would let clear the configuration bits. Another directed case checks that link pulses stay on in automatic mode while the AUI port is selected.

// File: rtl/media_sel_pkg.sv
// Package media_sel_pkg
// Shared types of the media port selector: the port encoding and the
// reset value of the selected port. It assumes exactly two media ports.
package media_sel_pkg;

    typedef enum logic {
        PORT_AUI = 1'b0,
        PORT_TP  = 1'b1
    } port_e;

    localparam port_e PORT_RESET = PORT_AUI;

    typedef struct packed {
        logic auto_sel;
        logic awake;
    } sel_cfg_t;

    localparam int CFG_W = $bits(sel_cfg_t);

endpackage

// File: rtl/msel_cfg_regs.sv
// Module msel_cfg_regs
// Holds the auto-select and awake configuration bits. A hard reset
// (synchronous, active low) clears them. A write strobe loads them. A soft
// reset has no effect here; that is why soft reset is not an input.
// Assumes the write strobe lasts one cycle per write, or repeats the value.
module msel_cfg_regs
    import media_sel_pkg::*;
#(
    parameter sel_cfg_t CFG_RESET = '0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  sel_cfg_t wdata,
    output sel_cfg_t cfg
);

    sel_cfg_t cfg_q;

    // Configuration register: clear on hard reset, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/msel_link_qual.sv
// Module msel_link_qual
// Combines the link indications into one pass flag. There is one source
// per entry of the input vector (received traffic, forced link test, ...).
// The link passes when any source is high. Assumes that every source is
// already in the clk domain.
module msel_link_qual #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] src,
    output logic               link_pass
);

    logic [NUM_SRC:0] chain;

    assign chain[0] = 1'b0;

    // OR chain over all link sources.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src[g];
    end

    assign link_pass = chain[NUM_SRC];

endmodule

// File: rtl/msel_port_ctrl.sv
// Module msel_port_ctrl
// Keeps the selected-port register. The target port is the link state in
// automatic mode and the software choice otherwise. The register loads the
// target only when no transmission is in progress, so a frame is never
// split between ports. A soft or hard reset sends the port to its reset
// value. Assumes tx_active stays high for the whole frame.
module msel_port_ctrl
    import media_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_rst,
    input  logic  auto_sel,
    input  logic  link_pass,
    input  logic  manual_port,
    input  logic  tx_active,
    output port_e port
);

    port_e target;
    port_e port_q;

    // Target port: the link state in automatic mode, software otherwise.
    always_comb begin
        if (auto_sel) begin
            target = link_pass ? PORT_TP : PORT_AUI;
        end else begin
            target = manual_port ? PORT_TP : PORT_AUI;
        end
    end

    // Port register: reset, then hold while transmitting.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            port_q <= PORT_RESET;
        end else if (!tx_active) begin
            port_q <= target;
        end
    end

    assign port = port_q;

endmodule

// File: rtl/msel_power_ctrl.sv
// Module msel_power_ctrl
// Sets the link pulse enable and turns a sleep request into snooze or
// coma. Snooze needs the awake bit and the twisted-pair port; every other
// sleep goes to coma. Purely combinational. Assumes that sleep_req is
// synchronous to clk.
module msel_power_ctrl
    import media_sel_pkg::*;
(
    input  logic  auto_sel,
    input  logic  awake,
    input  port_e port,
    input  logic  sleep_req,
    output logic  pulse_en,
    output logic  snooze,
    output logic  coma
);

    logic light_sleep_ok;

    // Link pulses: always in automatic mode, else only on twisted-pair.
    always_comb begin
        pulse_en = auto_sel || (port == PORT_TP);
    end

    // Sleep depth: snooze only with awake on the twisted-pair port.
    always_comb begin
        light_sleep_ok = awake && (port == PORT_TP);
        snooze         = sleep_req && light_sleep_ok;
        coma           = sleep_req && !light_sleep_ok;
    end

endmodule

// File: rtl/media_port_selector.sv
// Module media_port_selector
// Top of the media port selector. Joins the configuration bits, the link
// qualifier, the port register and the power logic. Hard reset is
// synchronous and active low. Soft reset resets only the port. Assumes
// that all inputs are synchronous to clk.
module media_port_selector
    import media_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic cfg_we,
    input  logic cfg_auto_sel,
    input  logic cfg_awake,
    input  logic manual_port,
    input  logic rx_link_ok,
    input  logic force_link,
    input  logic tx_active,
    input  logic sleep_req,
    output logic port_sel,
    output logic link_pulse_en,
    output logic snooze,
    output logic coma
);

    localparam int NUM_LINK_SRC = 2;

    sel_cfg_t                cfg_wdata;
    sel_cfg_t                cfg;
    logic [NUM_LINK_SRC-1:0] link_src;
    logic                    link_pass;
    port_e                   port;

    assign cfg_wdata.auto_sel = cfg_auto_sel;
    assign cfg_wdata.awake    = cfg_awake;
    assign link_src           = {force_link, rx_link_ok};

    msel_cfg_regs #(
        .CFG_RESET ('0)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    msel_link_qual #(
        .NUM_SRC (NUM_LINK_SRC)
    ) u_link (
        .src       (link_src),
        .link_pass (link_pass)
    );

    msel_port_ctrl u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .auto_sel    (cfg.auto_sel),
        .link_pass   (link_pass),
        .manual_port (manual_port),
        .tx_active   (tx_active),
        .port        (port)
    );

    msel_power_ctrl u_pwr (
        .auto_sel  (cfg.auto_sel),
        .awake     (cfg.awake),
        .port      (port),
        .sleep_req (sleep_req),
        .pulse_en  (link_pulse_en),
        .snooze    (snooze),
        .coma      (coma)
    );

    assign port_sel = (port == PORT_TP);

endmodule

// File: rtl/msel_checker.sv
// Module msel_checker
// Temporal checks on the media port selector, attached by bind.
module msel_checker (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic cfg_we,
    input logic auto_q,
    input logic awake_q,
    input logic link_pass,
    input logic rx_link_ok,
    input logic force_link,
    input logic tx_active,
    input logic sleep_req,
    input logic port_sel,
    input logic link_pulse_en,
    input logic snooze,
    input logic coma
);

    assert_auto_pass_tp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && !tx_active && !soft_rst && (rx_link_ok || force_link)) |=> port_sel);

    assert_auto_fail_aui_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && !tx_active && !soft_rst && !rx_link_ok && !force_link) |=> !port_sel);

    assert_pass_sources_R3: assert property (@(posedge clk) disable iff (!rst_n)
        link_pass == (rx_link_ok || force_link));

    assert_hold_in_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !soft_rst) |=> $stable(port_sel));

    assert_pulse_auto_R5: assert property (@(posedge clk) disable iff (!rst_n)
        auto_q |-> link_pulse_en);

    assert_sleep_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snooze, coma}) && ((snooze || coma) == sleep_req));

    assert_snooze_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> (awake_q && port_sel));

    assert_soft_keeps_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !cfg_we) |=> ($stable(auto_q) && $stable(awake_q) && !port_sel));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(auto_q) && $stable(awake_q)));

endmodule

bind media_port_selector msel_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .cfg_we        (cfg_we),
    .auto_q        (cfg.auto_sel),
    .awake_q       (cfg.awake),
    .link_pass     (link_pass),
    .rx_link_ok    (rx_link_ok),
    .force_link    (force_link),
    .tx_active     (tx_active),
    .sleep_req     (sleep_req),
    .port_sel      (port_sel),
    .link_pulse_en (link_pulse_en),
    .snooze        (snooze),
    .coma          (coma)
);

// File: tb/sim_media_port_selector.sv
module sim_media_port_selector;

    logic clk = 1'b0;
    logic rst_n, soft_rst, cfg_we, cfg_auto_sel, cfg_awake, manual_port;
    logic rx_link_ok, force_link, tx_active, sleep_req;
    logic port_sel, link_pulse_en, snooze, coma;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit m_auto, m_awake, m_port;

    always #4 clk = ~clk;

    media_port_selector u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
        .cfg_auto_sel(cfg_auto_sel), .cfg_awake(cfg_awake),
        .manual_port(manual_port), .rx_link_ok(rx_link_ok),
        .force_link(force_link), .tx_active(tx_active), .sleep_req(sleep_req),
        .port_sel(port_sel), .link_pulse_en(link_pulse_en),
        .snooze(snooze), .coma(coma)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({"R1 R2 R4 R6 R8 port_sel ", ctx}, port_sel, m_port);
        chk({"R5 R6 link_pulse_en ", ctx}, link_pulse_en, m_auto | m_port);
        chk({"R7 snooze ", ctx}, snooze, sleep_req & m_awake & m_port);
        chk({"R7 coma ", ctx}, coma, sleep_req & ~(m_awake & m_port));
    endtask

    // One cycle: drive at the falling edge, update the model at the rising
    // edge, compare shortly after it.
    task automatic step(input bit r, input bit sr, input bit we, input bit au,
                        input bit aw, input bit mp, input bit lk, input bit fl,
                        input bit tx, input bit sl, input string ctx);
        bit n_auto, n_awake, n_port;
        @(negedge clk);
        rst_n = r; soft_rst = sr; cfg_we = we; cfg_auto_sel = au;
        cfg_awake = aw; manual_port = mp; rx_link_ok = lk; force_link = fl;
        tx_active = tx; sleep_req = sl;
        n_auto = m_auto; n_awake = m_awake; n_port = m_port;
        if (!r) begin
            n_auto = 0; n_awake = 0; n_port = 0;
        end else begin
            if (we) begin n_auto = au; n_awake = aw; end
            if (sr) n_port = 0;
            else if (!tx) n_port = m_auto ? (lk | fl) : mp;
        end
        @(posedge clk);
        #1;
        m_auto = n_auto; m_awake = n_awake; m_port = n_port;
        check_all(ctx);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; soft_rst = 0; cfg_we = 0; cfg_auto_sel = 0; cfg_awake = 0;
        manual_port = 0; rx_link_ok = 0; force_link = 0; tx_active = 0; sleep_req = 0;
        m_auto = 0; m_awake = 0; m_port = 0;

        // R8: hard reset state, sleep pending shows coma on AUI.
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 1, "reset");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "post-reset");

        // R3: a forced link test alone selects twisted-pair in auto mode.
        step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, "enable auto");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R3 force only");
        chk("R3 forced link gives twisted-pair", port_sel, 1'b1);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 link lost");
        chk("R2 failed link gives AUI", port_sel, 1'b0);
        // R5: pulses stay on in auto mode while AUI is selected.
        chk("R5 pulses with AUI in auto", link_pulse_en, 1'b1);

        // R4: link returns during a frame; switch deferred to frame end.
        step(1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R4 tx start");
        chk("R4 no switch in tx", port_sel, 1'b0);
        step(1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R4 tx mid");
        step(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R4 tx end");
        chk("R4 pending switch applied", port_sel, 1'b1);

        // R8: soft reset keeps auto and awake; port back to AUI.
        step(1, 0, 1, 1, 1, 0, 1, 0, 0, 0, "set awake");
        step(1, 1, 0, 0, 0, 0, 1, 0, 0, 1, "R8 soft reset");
        chk("R8 soft reset port AUI", port_sel, 1'b0);
        chk("R7 awake on AUI gives coma", coma, 1'b1);
        step(1, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R8 after soft");
        chk("R8 awake kept: snooze", snooze, 1'b1);

        // R9 / R6: manual mode without write strobe keeps config.
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 no strobe");
        chk("R9 auto kept without strobe", link_pulse_en, 1'b1);

        // Exhaustive sweeps of control inputs in two orders.
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) begin
                int v;
                v = (pass == 0) ? i : ((i * 37 + 11) % 256);
                step(1, (v % 29) == 7, v[7], v[6], v[5], v[4], v[3], v[2],
                     v[1], v[0], "sweep");
            end
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "sweep reset");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule